// File: doc/BRIEF.md
# Eight-Bit Load Instruction Executor

This block runs the byte-move instructions of a small accumulator processor. It holds the registers A, B, C, D, E, H and L, and it also uses them in pairs (BC, DE, HL) as 16-bit memory pointers. A fetch unit outside the block presents an opcode byte and the two bytes that follow it, then pulses `start`. The block decodes the opcode and reports how many of the presented bytes the instruction uses. It then moves a byte between registers, between a register and memory, or from an inline constant to a register or to memory, and pulses `done` in the last cycle of the instruction.

Memory sits behind a single synchronous byte port. An address and write strobe presented in one cycle are captured at the next clock edge, and read data is returned one cycle after its address. The block also covers the instruction that stores the 16-bit stack pointer to an absolute address. The stack pointer value arrives on an input and is stored one byte per cycle. An opcode outside the load group is reported as illegal and has no effect.

Top module: `ld8_exec`

## Requirements
- R1: For opcodes 0x40 to 0x7F except 0x76, bits 5:3 select the destination and bits 2:0 the source, with register index B=0, C=1, D=2, E=3, H=4, L=5, A=7. A move between two registers is one byte long and asserts `done` in the first cycle after the `start` edge.
- R2: Opcodes 0x06, 0x0E, 0x16, 0x1E, 0x26, 0x2E and 0x3E write `opnd_lo` into B, C, D, E, H, L and A respectively. They are two bytes long.
- R3: Register index 6 in a move names the byte at address HL. As a source it gives a one-byte read whose `done` comes two cycles after `start`. As a destination it gives a one-byte write of the source register, with `done` one cycle after `start`.
- R4: 0x0A and 0x1A load A from the address in BC and in DE. 0x02 and 0x12 store A to those addresses. 0x36 writes `opnd_lo` to the address in HL and is two bytes long. The other four forms are one byte long.
- R5: 0xFA loads A from, and 0xEA stores A to, the address {`opnd_hi`,`opnd_lo`}. Both are three bytes long.
- R6: 0xF2 loads A from, and 0xE2 stores A to, 0xFF00+C; these are one byte long. 0xF0 and 0xE0 do the same at 0xFF00+`opnd_lo` and are two bytes long.
- R7: 0x2A loads A from the address in HL and then adds one to HL. 0x3A does the same but subtracts one. HL wraps modulo 2^16.
- R8: 0x08 is three bytes long. It writes `sp[7:0]` to {`opnd_hi`,`opnd_lo`} and then, in the next cycle, writes `sp[15:8]` to that address plus one, modulo 2^16. `done` marks the second write.
- R9: 0x76 and every opcode not listed in R1 to R8 assert `illegal` together with `done` one cycle after `start`. They report a length of 1 and leave all registers and memory unchanged.
- R10: `busy` is high from the cycle after `start` is accepted until the cycle that carries `done`. A `start` while busy is ignored. No memory write happens while not busy.
- R11: After reset all registers read 0, and `busy`, `done` and `mem_we` are low.
- R12: `instr_len` holds the executed instruction's length (1, 2 or 3) while `done` is high. Bytes beyond that length never affect any register or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the presented instruction (accepted when not busy) |
| opcode | input | 8 | Opcode byte |
| opnd_lo | input | 8 | First byte after the opcode |
| opnd_hi | input | 8 | Second byte after the opcode |
| sp | input | 16 | Stack pointer value, sampled with `start` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| illegal | output | 1 | Opcode is not a supported load, valid with `done` |
| instr_len | output | 2 | Bytes used by the instruction, valid with `done` |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after its address |
| rd_sel | input | 3 | Register index to observe (R1 encoding; 6 reads 0) |
| rd_data | output | 8 | Value of the selected register |

## Verification
A wrong decode shows up in the same instruction, as a wrong `instr_len`, a missing or extra write on the memory port, or a `done` pulse in the wrong cycle. A stale or wrongly stepped HL pointer only shows up when a later instruction uses HL as an address. For that reason every instruction is followed by a readout of all seven registers, and the write log is compared address by address. The stack-pointer store is checked on both write cycles, and the bench uses an address that wraps past 0xFFFF.

// File: rtl/ld8_pkg.sv
package ld8_pkg;

    localparam int DW     = 8;
    localparam int AW     = 2 * DW;
    localparam int NREG   = 8;
    localparam int IDX_W  = $clog2(NREG);

    localparam logic [IDX_W-1:0] IDX_B   = 3'd0;
    localparam logic [IDX_W-1:0] IDX_C   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_D   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_E   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_H   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_L   = 3'd5;
    localparam logic [IDX_W-1:0] IDX_MEM = 3'd6;
    localparam logic [IDX_W-1:0] IDX_A   = 3'd7;

    typedef enum logic [2:0] {
        K_MOVE,    // register to register
        K_IMM,     // inline byte to register
        K_LOAD,    // memory to register
        K_STORE,   // register to memory
        K_STIMM,   // inline byte to memory
        K_SPST,    // stack pointer, two byte writes
        K_BAD      // not a load
    } kind_e;

    typedef enum logic [2:0] {
        A_HL, A_BC, A_DE, A_ABS, A_IOC, A_IOIMM
    } asrc_e;

    typedef enum logic [1:0] {
        HL_KEEP, HL_INC, HL_DEC
    } hlstep_e;

    typedef enum logic [1:0] {
        W_REG, W_IMM, W_MEM
    } wsel_e;

    typedef enum logic [1:0] {
        S_IDLE, S_EXEC, S_READ, S_WR2
    } st_e;

    typedef struct packed {
        kind_e             kind;
        asrc_e             asrc;
        hlstep_e           step;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  src;
        logic [1:0]        len;
    } uop_t;

    function automatic uop_t mk_uop(kind_e k, asrc_e a, hlstep_e s,
                                    logic [IDX_W-1:0] d, logic [IDX_W-1:0] r,
                                    logic [1:0] n);
        uop_t u;
        u.kind = k;
        u.asrc = a;
        u.step = s;
        u.dst  = d;
        u.src  = r;
        u.len  = n;
        return u;
    endfunction

    function automatic logic [AW-1:0] join_pair(logic [DW-1:0] hi, logic [DW-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/ld8_decode.sv
module ld8_decode
    import ld8_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output uop_t          uop
);

    logic [IDX_W-1:0] f_dst;
    logic [IDX_W-1:0] f_src;

    assign f_dst = opcode[5:3];
    assign f_src = opcode[2:0];

    always_comb begin
        uop = mk_uop(K_BAD, A_HL, HL_KEEP, IDX_A, IDX_A, 2'd1);
        if (opcode[7:6] == 2'b01) begin
            if (f_dst == IDX_MEM && f_src == IDX_MEM) begin
                uop = mk_uop(K_BAD, A_HL, HL_KEEP, IDX_A, IDX_A, 2'd1);
            end else if (f_src == IDX_MEM) begin
                uop = mk_uop(K_LOAD, A_HL, HL_KEEP, f_dst, f_src, 2'd1);
            end else if (f_dst == IDX_MEM) begin
                uop = mk_uop(K_STORE, A_HL, HL_KEEP, f_dst, f_src, 2'd1);
            end else begin
                uop = mk_uop(K_MOVE, A_HL, HL_KEEP, f_dst, f_src, 2'd1);
            end
        end else if (opcode[7:6] == 2'b00 && f_src == IDX_MEM) begin
            if (f_dst == IDX_MEM)
                uop = mk_uop(K_STIMM, A_HL, HL_KEEP, f_dst, f_src, 2'd2);
            else
                uop = mk_uop(K_IMM, A_HL, HL_KEEP, f_dst, f_src, 2'd2);
        end else begin
            unique case (opcode)
                8'h0A: uop = mk_uop(K_LOAD,  A_BC,    HL_KEEP, IDX_A, IDX_A, 2'd1);
                8'h1A: uop = mk_uop(K_LOAD,  A_DE,    HL_KEEP, IDX_A, IDX_A, 2'd1);
                8'h02: uop = mk_uop(K_STORE, A_BC,    HL_KEEP, IDX_A, IDX_A, 2'd1);
                8'h12: uop = mk_uop(K_STORE, A_DE,    HL_KEEP, IDX_A, IDX_A, 2'd1);
                8'h2A: uop = mk_uop(K_LOAD,  A_HL,    HL_INC,  IDX_A, IDX_A, 2'd1);
                8'h3A: uop = mk_uop(K_LOAD,  A_HL,    HL_DEC,  IDX_A, IDX_A, 2'd1);
                8'hFA: uop = mk_uop(K_LOAD,  A_ABS,   HL_KEEP, IDX_A, IDX_A, 2'd3);
                8'hEA: uop = mk_uop(K_STORE, A_ABS,   HL_KEEP, IDX_A, IDX_A, 2'd3);
                8'hF2: uop = mk_uop(K_LOAD,  A_IOC,   HL_KEEP, IDX_A, IDX_A, 2'd1);
                8'hE2: uop = mk_uop(K_STORE, A_IOC,   HL_KEEP, IDX_A, IDX_A, 2'd1);
                8'hF0: uop = mk_uop(K_LOAD,  A_IOIMM, HL_KEEP, IDX_A, IDX_A, 2'd2);
                8'hE0: uop = mk_uop(K_STORE, A_IOIMM, HL_KEEP, IDX_A, IDX_A, 2'd2);
                8'h08: uop = mk_uop(K_SPST,  A_ABS,   HL_KEEP, IDX_A, IDX_A, 2'd3);
                default: uop = mk_uop(K_BAD, A_HL,    HL_KEEP, IDX_A, IDX_A, 2'd1);
            endcase
        end
    end

endmodule

// File: rtl/ld8_seq.sv
module ld8_seq
    import ld8_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  uop_t           uop_in,
    input  logic [DW-1:0]  lo_in,
    input  logic [DW-1:0]  hi_in,
    input  logic [AW-1:0]  sp_in,
    output st_e            state,
    output uop_t           uop_q,
    output logic [DW-1:0]  lo_q,
    output logic [DW-1:0]  hi_q,
    output logic [AW-1:0]  sp_q,
    output logic           busy,
    output logic           done,
    output logic           illegal,
    output logic           mem_we,
    output logic           rf_we,
    output wsel_e          rf_wsel,
    output hlstep_e        hl_step
);

    logic exec_ph;
    logic multi;

    assign exec_ph = (state == S_EXEC);
    assign multi   = (uop_q.kind == K_LOAD) || (uop_q.kind == K_SPST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            uop_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            sp_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        uop_q <= uop_in;
                        lo_q  <= lo_in;
                        hi_q  <= hi_in;
                        sp_q  <= sp_in;
                        state <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    if (uop_q.kind == K_LOAD)
                        state <= S_READ;
                    else if (uop_q.kind == K_SPST)
                        state <= S_WR2;
                    else
                        state <= S_IDLE;
                end
                S_READ:  state <= S_IDLE;
                S_WR2:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state != S_IDLE);
        done    = (exec_ph && !multi) || (state == S_READ) || (state == S_WR2);
        illegal = exec_ph && (uop_q.kind == K_BAD);
        mem_we  = (exec_ph && (uop_q.kind inside {K_STORE, K_STIMM, K_SPST}))
               || (state == S_WR2);
        rf_we   = (exec_ph && (uop_q.kind inside {K_MOVE, K_IMM}))
               || (state == S_READ);
        if (state == S_READ)
            rf_wsel = W_MEM;
        else if (uop_q.kind == K_IMM)
            rf_wsel = W_IMM;
        else
            rf_wsel = W_REG;
        hl_step = (state == S_READ) ? uop_q.step : HL_KEEP;
    end

    AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (rst) done |=> !done);                 // R10
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_we);             // R10
    AST_BAD_NO_WRITE:  assert property (@(posedge clk) disable iff (rst) illegal |-> (!mem_we && !rf_we)); // R9
    AST_BAD_WITH_DONE: assert property (@(posedge clk) disable iff (rst) illegal |-> done);              // R9
    AST_WR2_AFTER_WR:  assert property (@(posedge clk) disable iff (rst) (state == S_WR2) |-> $past(mem_we)); // R8

endmodule

// File: rtl/ld8_regfile.sv
module ld8_regfile
    import ld8_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          waddr,
    input  logic [DW-1:0]             wdata,
    input  hlstep_e                   step,
    output logic [NREG-1:0][DW-1:0]   regs_o
);

    logic [DW-1:0] r [NREG];
    logic [AW-1:0] hl_now;
    logic [AW-1:0] hl_nxt;
    logic          hl_move;
    logic          hl_hit;

    assign hl_now  = join_pair(r[IDX_H], r[IDX_L]);
    assign hl_move = (step != HL_KEEP);
    assign hl_nxt  = (step == HL_INC) ? hl_now + AW'(1) : hl_now - AW'(1);
    assign hl_hit  = we && (waddr == IDX_H || waddr == IDX_L);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == IDX_MEM) begin : g_hole
            assign r[i] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst)
                    r[i] <= '0;
                else if (we && waddr == IDX_W'(i))
                    r[i] <= wdata;
                else if (hl_move && i == IDX_H)
                    r[i] <= hl_nxt[AW-1:DW];
                else if (hl_move && i == IDX_L)
                    r[i] <= hl_nxt[DW-1:0];
            end
        end
        assign regs_o[i] = r[i];
    end

    AST_HL_INC: assert property (@(posedge clk) disable iff (rst)
        (step == HL_INC && !hl_hit) |=> hl_now == $past(hl_now) + AW'(1));   // R7
    AST_HL_DEC: assert property (@(posedge clk) disable iff (rst)
        (step == HL_DEC && !hl_hit) |=> hl_now == $past(hl_now) - AW'(1));   // R7

endmodule

// File: rtl/ld8_exec.sv
module ld8_exec
    import ld8_pkg::*;
#(
    parameter logic [7:0] IO_PAGE = 8'hFF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [7:0]   opcode,
    input  logic [7:0]   opnd_lo,
    input  logic [7:0]   opnd_hi,
    input  logic [15:0]  sp,
    output logic         busy,
    output logic         done,
    output logic         illegal,
    output logic [1:0]   instr_len,
    output logic [15:0]  mem_addr,
    output logic         mem_we,
    output logic [7:0]   mem_wdata,
    input  logic [7:0]   mem_rdata,
    input  logic [2:0]   rd_sel,
    output logic [7:0]   rd_data
);

    uop_t                     uop_dec;
    uop_t                     uop_q;
    st_e                      state;
    logic [DW-1:0]            lo_q;
    logic [DW-1:0]            hi_q;
    logic [AW-1:0]            sp_q;
    logic                     rf_we;
    wsel_e                    rf_wsel;
    hlstep_e                  hl_step;
    logic [DW-1:0]            rf_wdata;
    logic [NREG-1:0][DW-1:0]  regs;
    logic [AW-1:0]            base_addr;
    logic                     second;

    ld8_decode u_decode (
        .opcode (opcode),
        .uop    (uop_dec)
    );

    ld8_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .uop_in  (uop_dec),
        .lo_in   (opnd_lo),
        .hi_in   (opnd_hi),
        .sp_in   (sp),
        .state   (state),
        .uop_q   (uop_q),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .sp_q    (sp_q),
        .busy    (busy),
        .done    (done),
        .illegal (illegal),
        .mem_we  (mem_we),
        .rf_we   (rf_we),
        .rf_wsel (rf_wsel),
        .hl_step (hl_step)
    );

    ld8_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (uop_q.dst),
        .wdata  (rf_wdata),
        .step   (hl_step),
        .regs_o (regs)
    );

    assign second = (state == S_WR2);

    always_comb begin
        unique case (uop_q.asrc)
            A_BC:    base_addr = join_pair(regs[IDX_B], regs[IDX_C]);
            A_DE:    base_addr = join_pair(regs[IDX_D], regs[IDX_E]);
            A_ABS:   base_addr = join_pair(hi_q, lo_q);
            A_IOC:   base_addr = join_pair(IO_PAGE, regs[IDX_C]);
            A_IOIMM: base_addr = join_pair(IO_PAGE, lo_q);
            default: base_addr = join_pair(regs[IDX_H], regs[IDX_L]);
        endcase
        mem_addr = second ? base_addr + AW'(1) : base_addr;
    end

    always_comb begin
        if (uop_q.kind == K_SPST)
            mem_wdata = second ? sp_q[AW-1:DW] : sp_q[DW-1:0];
        else if (uop_q.kind == K_STIMM)
            mem_wdata = lo_q;
        else
            mem_wdata = regs[uop_q.src];
    end

    always_comb begin
        unique case (rf_wsel)
            W_IMM:   rf_wdata = lo_q;
            W_MEM:   rf_wdata = mem_rdata;
            default: rf_wdata = regs[uop_q.src];
        endcase
    end

    assign instr_len = uop_q.len;
    assign rd_data   = regs[rd_sel];

    AST_SP_HIGH_NEXT:  assert property (@(posedge clk) disable iff (rst)
        second |-> mem_addr == $past(mem_addr) + AW'(1));                        // R8
    AST_BAD_KEEPS_REG: assert property (@(posedge clk) disable iff (rst)
        illegal |=> regs == $past(regs));                                        // R9
    AST_IO_PAGE:       assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && uop_q.kind != K_BAD && uop_q.asrc inside {A_IOC, A_IOIMM})
        |-> mem_addr[AW-1:DW] == IO_PAGE);                                       // R6
    AST_LEN_RANGE:     assert property (@(posedge clk) disable iff (rst)
        done |-> (instr_len != 2'd0));                                           // R12

endmodule

// File: tb/test_ld8_exec.sv
`timescale 1ns/1ps
module test_ld8_exec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, opnd_lo = '0, opnd_hi = '0;
    logic [15:0] sp = '0;
    logic        busy, done, illegal;
    logic [1:0]  instr_len;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_data;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    ld8_exec i_ld8_exec (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .sp(sp),
        .busy(busy), .done(done), .illegal(illegal), .instr_len(instr_len),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // sparse byte memory: 256 slots tagged with the high address byte
    logic [7:0] m_dat [256];
    logic [7:0] m_tag [256];
    bit         m_val [256];
    int         wr_cnt;
    logic [15:0] wr_a [2];
    logic [7:0]  wr_d [2];

    function automatic logic [7:0] peek(logic [15:0] a);
        if (m_val[a[7:0]] && m_tag[a[7:0]] == a[15:8]) return m_dat[a[7:0]];
        return a[15:8] ^ a[7:0] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= peek(mem_addr);
        if (mem_we) begin
            m_dat[mem_addr[7:0]] <= mem_wdata;
            m_tag[mem_addr[7:0]] <= mem_addr[15:8];
            m_val[mem_addr[7:0]] <= 1'b1;
            if (wr_cnt < 2) begin
                wr_a[wr_cnt] <= mem_addr;
                wr_d[wr_cnt] <= mem_wdata;
            end
            wr_cnt <= wr_cnt + 1;
        end
    end

    // reference register model, index B0 C1 D2 E3 H4 L5 A7
    logic [7:0]  mreg [8];
    bit          e_bad;
    int          e_len, e_lat, e_nw;
    logic [15:0] e_wa [2];
    logic [7:0]  e_wd [2];
    string       e_tag;

    function automatic logic [15:0] hl();
        return {mreg[4], mreg[5]};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic exp_wr(input logic [15:0] a, input logic [7:0] d);
        e_wa[e_nw] = a;
        e_wd[e_nw] = d;
        e_nw++;
    endtask

    task automatic model(input logic [7:0] op, b1, b2, input logic [15:0] spv);
        logic [2:0]  d, s;
        logic [15:0] p;
        e_bad = 0; e_len = 1; e_lat = 1; e_nw = 0; e_tag = "R9";
        d = op[5:3]; s = op[2:0];
        if (op[7:6] == 2'b01 && op != 8'h76) begin
            if (s == 3'd6) begin
                e_tag = "R3"; e_lat = 2; mreg[d] = peek(hl());
            end else if (d == 3'd6) begin
                e_tag = "R3"; exp_wr(hl(), mreg[s]);
            end else begin
                e_tag = "R1"; mreg[d] = mreg[s];
            end
        end else if (op[7:6] == 2'b00 && s == 3'd6) begin
            e_len = 2;
            if (d == 3'd6) begin e_tag = "R4"; exp_wr(hl(), b1); end
            else begin e_tag = "R2"; mreg[d] = b1; end
        end else begin
            case (op)
                8'h0A: begin e_tag = "R4"; e_lat = 2; mreg[7] = peek({mreg[0], mreg[1]}); end
                8'h1A: begin e_tag = "R4"; e_lat = 2; mreg[7] = peek({mreg[2], mreg[3]}); end
                8'h02: begin e_tag = "R4"; exp_wr({mreg[0], mreg[1]}, mreg[7]); end
                8'h12: begin e_tag = "R4"; exp_wr({mreg[2], mreg[3]}, mreg[7]); end
                8'h2A, 8'h3A: begin
                    e_tag = "R7"; e_lat = 2; mreg[7] = peek(hl());
                    p = (op == 8'h2A) ? hl() + 16'd1 : hl() - 16'd1;
                    mreg[4] = p[15:8]; mreg[5] = p[7:0];
                end
                8'hFA: begin e_tag = "R5"; e_len = 3; e_lat = 2; mreg[7] = peek({b2, b1}); end
                8'hEA: begin e_tag = "R5"; e_len = 3; exp_wr({b2, b1}, mreg[7]); end
                8'hF2: begin e_tag = "R6"; e_lat = 2; mreg[7] = peek({8'hFF, mreg[1]}); end
                8'hE2: begin e_tag = "R6"; exp_wr({8'hFF, mreg[1]}, mreg[7]); end
                8'hF0: begin e_tag = "R6"; e_len = 2; e_lat = 2; mreg[7] = peek({8'hFF, b1}); end
                8'hE0: begin e_tag = "R6"; e_len = 2; exp_wr({8'hFF, b1}, mreg[7]); end
                8'h08: begin
                    e_tag = "R8"; e_len = 3; e_lat = 2;
                    exp_wr({b2, b1}, spv[7:0]);
                    exp_wr({b2, b1} + 16'd1, spv[15:8]);
                end
                default: e_bad = 1;
            endcase
        end
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 8; i++) begin
            if (i == 6) continue;
            rd_sel = 3'(i);
            #0.1;
            check(tag, $sformatf("reg%0d", i), rd_data, mreg[i]);
        end
    endtask

    task automatic run_op(input logic [7:0] op, b1, b2, input bit poke);
        logic [15:0] spv;
        int          cnt;
        bit          s_bad;
        int          s_len;
        spv = 16'($urandom);
        model(op, b1, b2, spv);
        @(negedge clk);
        opcode = op; opnd_lo = b1; opnd_hi = b2; sp = spv; start = 1'b1;
        wr_cnt = 0;
        cnt = 0; s_bad = 0; s_len = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                check("R10", "busy", busy, 1);
                if (poke) begin opcode = 8'h3E; opnd_lo = 8'hEE; end   // R10 start while busy
                else start = 1'b0;
            end else start = 1'b0;
            if (done) begin s_bad = illegal; s_len = instr_len; end
        end while (!done && cnt < 8);
        @(posedge clk);
        #1 start = 1'b0;
        check(e_tag, "latency", cnt, e_lat);
        check(e_bad ? "R9" : e_tag, "illegal", s_bad, e_bad);
        check("R12", "length", s_len, e_len);
        check(e_tag, "write count", wr_cnt, e_nw);
        for (int k = 0; k < e_nw && k < wr_cnt; k++) begin
            check(e_tag, "write addr", wr_a[k], e_wa[k]);
            check(e_tag, "write data", wr_d[k], e_wd[k]);
        end
        check_regs(e_tag);
    endtask

    logic [7:0] grp [21] = '{8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h3E,
                             8'h36, 8'h0A, 8'h1A, 8'h02, 8'h12, 8'h2A, 8'h3A,
                             8'hFA, 8'hEA, 8'hF2, 8'hE2, 8'hF0, 8'hE0, 8'h08};

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin m_val[i] = 0; m_dat[i] = '0; m_tag[i] = '0; end
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        wr_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11 reset state
        @(negedge clk);
        check("R11", "busy", busy, 0);
        check("R11", "done", done, 0);
        check("R11", "mem_we", mem_we, 0);
        check_regs("R11");

        // R2 immediates, trailing bytes differ
        run_op(8'h06, 8'h12, 8'hAA, 0);
        run_op(8'h0E, 8'h34, 8'hBB, 0);
        run_op(8'h16, 8'h56, 8'hCC, 0);
        run_op(8'h1E, 8'h78, 8'hDD, 0);
        run_op(8'h26, 8'hC0, 8'hEE, 0);
        run_op(8'h2E, 8'h10, 8'hFF, 0);
        run_op(8'h3E, 8'h9A, 8'h11, 0);
        // R1 moves, R3 memory via HL
        run_op(8'h78, 8'h00, 8'h00, 0);
        run_op(8'h45, 8'h00, 8'h00, 0);
        run_op(8'h77, 8'h00, 8'h00, 0);
        run_op(8'h7E, 8'h00, 8'h00, 0);
        run_op(8'h66, 8'h00, 8'h00, 0);
        // R4 pointer forms
        run_op(8'h36, 8'h5C, 8'h99, 0);
        run_op(8'h02, 8'h00, 8'h00, 0);
        run_op(8'h0A, 8'h00, 8'h00, 0);
        run_op(8'h12, 8'h00, 8'h00, 0);
        run_op(8'h1A, 8'h00, 8'h00, 0);
        // R5 absolute store then load back
        run_op(8'h3E, 8'h69, 8'h00, 0);
        run_op(8'hEA, 8'hDE, 8'hCC, 0);
        run_op(8'h3E, 8'h00, 8'h00, 0);
        run_op(8'hFA, 8'hDE, 8'hCC, 0);
        // R6 high page forms
        run_op(8'h0E, 8'h64, 8'h00, 0);
        run_op(8'hE2, 8'h00, 8'h00, 0);
        run_op(8'hF2, 8'h00, 8'h00, 0);
        run_op(8'hE0, 8'h05, 8'h06, 0);
        run_op(8'hF0, 8'h05, 8'h06, 0);
        // R7 pointer step with wrap
        run_op(8'h26, 8'hFF, 8'h00, 0);
        run_op(8'h2E, 8'hFF, 8'h00, 0);
        run_op(8'h2A, 8'h00, 8'h00, 0);
        run_op(8'h3A, 8'h00, 8'h00, 0);
        run_op(8'h3A, 8'h00, 8'h00, 0);
        // R8 stack pointer store, plain and wrapping
        run_op(8'h08, 8'hAA, 8'hFF, 0);
        run_op(8'h08, 8'hFF, 8'hFF, 0);
        // R9 illegal opcodes
        run_op(8'h76, 8'h00, 8'h00, 0);
        run_op(8'hC3, 8'h12, 8'h34, 0);
        run_op(8'h00, 8'h00, 8'h00, 0);
        // R10 start held while busy
        run_op(8'h41, 8'h00, 8'h00, 1);
        run_op(8'h7E, 8'h00, 8'h00, 1);
        run_op(8'h08, 8'h10, 8'h20, 1);

        for (int it = 0; it < 400; it++) begin
            logic [7:0] op;
            r = $urandom_range(0, 3);
            if (r < 2)       op = 8'h40 + 8'($urandom_range(0, 63));
            else if (r == 2) op = grp[$urandom_range(0, 20)];
            else             op = 8'($urandom);
            run_op(op, 8'($urandom), 8'($urandom), ($urandom_range(0, 7) == 0));
        end
        finish_up();
    end

endmodule